// File: doc/BRIEF.md
# Overhead Serial Frame Formatter

The formatter produces the serial overhead stream for whichever port is currently receiving overhead service. An external timing chain supplies a word counter and a bit counter that together walk through a minor frame. The formatter watches those counters and places a single overhead bit in the first bit position (bit 0) of a fixed band of words. That bit goes to the overhead input of the downstream output multiplexer. Every other bit time carries a zero.

Inside that band there are two fields:
- **Words 1 to 23** carry a stuff command. The command is positive stuff, negative stuff or no action, and it is spread redundantly across all 23 words so that a receiver can take a majority vote.
- **Words 24 to 28** carry the 5-bit binary number of the serviced port.

The port number and the command are taken once, at the clock edge where the counters show the start of a minor frame. They are then held for the rest of that frame. Input changes at any other time therefore cannot corrupt a frame that is already being sent.

Top module: `overhead_formatter`

## Requirements
- R1: `ohBit` is 0 whenever `bitIdx` is not 0, and whenever `wordIdx` is 0 or greater than 28.
- R2: While the held command is positive stuff (`cmdSel` = 2'b01), `ohBit` is 1 at bit 0 of every word from 1 to 23.
- R3: While the held command is negative stuff (`cmdSel` = 2'b10), `ohBit` is 0 at bit 0 of every word from 1 to 23.
- R4: While the held command is no action (`cmdSel` = 2'b00 or 2'b11), `ohBit` at bit 0 of words 1 to 23 alternates, starting with 1. It is 1 in odd-numbered words and 0 in even-numbered words.
- R5: At bit 0 of words 24 to 28, `ohBit` carries the held 5-bit port number, most significant bit first. Word 24 carries port bit 4 and word 28 carries port bit 0.
- R6: `portSel` and `cmdSel` are captured only at a rising clock edge where `wordIdx` = 0 and `bitIdx` = 0. Changes on these inputs at any other edge have no effect on `ohBit` until the next frame start.
- R7: While `rst_n` is low, and after reset until the first frame start, the held values are port 0 with the no action command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wordIdx | input | WORD_W (6) | Word number within the minor frame |
| bitIdx | input | BIT_W (3) | Bit number within the word |
| portSel | input | PORT_W (5) | Number of the port being serviced |
| cmdSel | input | 2 | Stuff command: 01 positive, 10 negative, 00 or 11 no action |
| ohBit | output | 1 | Serial overhead bit |

## Verification
The hardest case to reach is an input change that lands exactly on a frame-start edge or one cycle either side of it. Only the value present at the frame-start edge may affect the frame that follows.

To cover this, the stimulus presents the value intended for the frame only at word 0, bit 0. In every other cycle it drives unrelated random port numbers and commands. Any leak from an off-edge value then shows up as a mismatch, either in the command field or in the port field.

A reference model follows the frame cycle by cycle. It is checked against:
- directed frames that use each command, including the alternate no-action code;
- the extreme port numbers;
- the reset-held state before any frame start has been seen.

// File: rtl/ohfmt_pkg.sv
package ohfmt_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE    = 2'b00,
    CMD_POS     = 2'b01,
    CMD_NEG     = 2'b10,
    CMD_IDLE_B  = 2'b11
  } stuffCmd_e;

  localparam int SLOT_IDX_W = 8;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic                  frameStart;
    logic                  cmdSlot;
    logic                  idSlot;
    logic                  leadPhase;
    logic [SLOT_IDX_W-1:0] idBit;
  } slotStrobe_t;

endpackage

// File: rtl/ohfmt_ctrl.sv
module ohfmt_ctrl
  import ohfmt_pkg::*;
#(
  parameter int WORD_W    = 6,
  parameter int BIT_W     = 3,
  parameter int PORT_W    = 5,
  parameter int CMD_FIRST = 1,
  parameter int CMD_WORDS = 23
) (
  input  logic [WORD_W-1:0] wordIdx,
  input  logic [BIT_W-1:0]  bitIdx,
  output slotStrobe_t       strobe
);

  localparam int CMD_LAST = CMD_FIRST + CMD_WORDS - 1;
  localparam int ID_FIRST = CMD_LAST + 1;
  localparam int ID_LAST  = ID_FIRST + PORT_W - 1;

  localparam logic [WORD_W-1:0] CMD_FIRST_W = WORD_W'(CMD_FIRST);
  localparam logic [WORD_W-1:0] CMD_LAST_W  = WORD_W'(CMD_LAST);
  localparam logic [WORD_W-1:0] ID_FIRST_W  = WORD_W'(ID_FIRST);
  localparam logic [WORD_W-1:0] ID_LAST_W   = WORD_W'(ID_LAST);

  logic              bitZero;
  logic [WORD_W-1:0] cmdOff;
  logic [WORD_W-1:0] idOff;

  always_comb begin
    bitZero = (bitIdx == '0);
    cmdOff  = wordIdx - CMD_FIRST_W;
    idOff   = ID_LAST_W - wordIdx;

    strobe.frameStart = bitZero && (wordIdx == '0);
    strobe.cmdSlot    = bitZero && (wordIdx >= CMD_FIRST_W) && (wordIdx <= CMD_LAST_W);
    strobe.idSlot     = bitZero && (wordIdx >= ID_FIRST_W) && (wordIdx <= ID_LAST_W);
    strobe.leadPhase  = ~cmdOff[0];
    strobe.idBit      = SLOT_IDX_W'(idOff);
  end

endmodule

// File: rtl/ohfmt_datapath.sv
module ohfmt_datapath
  import ohfmt_pkg::*;
#(
  parameter int PORT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slotStrobe_t       strobe,
  input  logic [PORT_W-1:0] portSel,
  input  logic [1:0]        cmdSel,
  output logic [PORT_W-1:0] heldPort,
  output stuffCmd_e         heldCmd,
  output logic              ohBit
);

  logic cmdBit;
  logic idVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldPort <= '0;
      heldCmd  <= CMD_IDLE;
    end else if (strobe.frameStart) begin
      heldPort <= portSel;
      heldCmd  <= stuffCmd_e'(cmdSel);
    end
  end

  always_comb begin
    case (heldCmd)
      CMD_POS: cmdBit = 1'b1;
      CMD_NEG: cmdBit = 1'b0;
      default: cmdBit = strobe.leadPhase;
    endcase
  end

  always_comb begin
    idVal = 1'b0;
    for (int i = 0; i < PORT_W; i++) begin
      if (strobe.idBit == SLOT_IDX_W'(i)) idVal = heldPort[i];
    end
  end

  assign ohBit = (strobe.cmdSlot & cmdBit) | (strobe.idSlot & idVal);

endmodule

// File: rtl/overhead_formatter.sv
module overhead_formatter
  import ohfmt_pkg::*;
#(
  parameter int WORD_W    = 6,
  parameter int BIT_W     = 3,
  parameter int PORT_W    = 5,
  parameter int CMD_FIRST = 1,
  parameter int CMD_WORDS = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] wordIdx,
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic [PORT_W-1:0] portSel,
  input  logic [1:0]        cmdSel,
  output logic              ohBit
);

  slotStrobe_t       strobe;
  logic [PORT_W-1:0] heldPort;
  stuffCmd_e         heldCmd;

  ohfmt_ctrl #(
    .WORD_W(WORD_W), .BIT_W(BIT_W), .PORT_W(PORT_W),
    .CMD_FIRST(CMD_FIRST), .CMD_WORDS(CMD_WORDS)
  ) u_ctrl (
    .wordIdx(wordIdx),
    .bitIdx (bitIdx),
    .strobe (strobe)
  );

  ohfmt_datapath #(.PORT_W(PORT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .portSel (portSel),
    .cmdSel  (cmdSel),
    .heldPort(heldPort),
    .heldCmd (heldCmd),
    .ohBit   (ohBit)
  );

endmodule

// File: rtl/ohfmt_chk.sv
module ohfmt_chk #(
  parameter int WORD_W    = 6,
  parameter int BIT_W     = 3,
  parameter int PORT_W    = 5,
  parameter int CMD_FIRST = 1,
  parameter int CMD_WORDS = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] wordIdx,
  input logic [BIT_W-1:0]  bitIdx,
  input logic [PORT_W-1:0] portSel,
  input logic [PORT_W-1:0] heldPort,
  input logic [1:0]        heldCmd,
  input logic              ohBit
);

  localparam int CMD_LAST = CMD_FIRST + CMD_WORDS - 1;
  localparam int ID_FIRST = CMD_LAST + 1;
  localparam int ID_LAST  = ID_FIRST + PORT_W - 1;

  logic inCmd, inId, atStart, outside, expId;
  int   wInt;

  always_comb begin
    wInt    = int'(wordIdx);
    atStart = (bitIdx == '0) && (wInt == 0);
    inCmd   = (bitIdx == '0) && (wInt >= CMD_FIRST) && (wInt <= CMD_LAST);
    inId    = (bitIdx == '0) && (wInt >= ID_FIRST) && (wInt <= ID_LAST);
    outside = (bitIdx != '0) || (wInt < CMD_FIRST) || (wInt > ID_LAST);
    expId   = 1'b0;
    for (int i = 0; i < PORT_W; i++) begin
      if (ID_LAST - wInt == i) expId = heldPort[i];
    end
  end

  // R1
  quiet_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> !ohBit);

  // R2
  pos_stuff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inCmd && heldCmd == 2'b01) |-> ohBit);

  // R3
  neg_stuff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inCmd && heldCmd == 2'b10) |-> !ohBit);

  // R4
  idle_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inCmd && (heldCmd == 2'b00 || heldCmd == 2'b11)) |-> (ohBit == ((wInt - CMD_FIRST) % 2 == 0)));

  // R5
  port_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inId |-> (ohBit == expId));

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    atStart |=> (heldPort == $past(portSel)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !atStart |=> $stable(heldPort) && $stable(heldCmd));

endmodule

bind overhead_formatter ohfmt_chk #(
  .WORD_W(WORD_W), .BIT_W(BIT_W), .PORT_W(PORT_W),
  .CMD_FIRST(CMD_FIRST), .CMD_WORDS(CMD_WORDS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wordIdx (wordIdx),
  .bitIdx  (bitIdx),
  .portSel (portSel),
  .heldPort(heldPort),
  .heldCmd (heldCmd),
  .ohBit   (ohBit)
);

// File: tb/overhead_formatter_bench.sv
module overhead_formatter_bench;

  localparam int WORDS = 32;
  localparam int BITS  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] wordIdx = '0;
  logic [2:0] bitIdx = '0;
  logic [4:0] portSel = '0;
  logic [1:0] cmdSel = '0;
  logic       ohBit;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int mPort = 0;
  int mCmd = 0;

  always #4 clk = ~clk;

  overhead_formatter u_overhead_formatter (
    .clk(clk), .rst_n(rst_n), .wordIdx(wordIdx), .bitIdx(bitIdx),
    .portSel(portSel), .cmdSel(cmdSel), .ohBit(ohBit)
  );

  function automatic string reqOf(int w, int b);
    if (b != 0 || w < 1 || w > 28) return "R1";
    if (w >= 24) return "R5";
    if (mCmd == 1) return "R2";
    if (mCmd == 2) return "R3";
    return "R4";
  endfunction

  function automatic bit modelBit(int w, int b);
    if (b != 0 || w < 1 || w > 28) return 1'b0;
    if (w >= 24) return 1'(mPort >> (28 - w));
    if (mCmd == 1) return 1'b1;
    if (mCmd == 2) return 1'b0;
    return 1'(w % 2);
  endfunction

  task automatic check(string req, bit exp);
    checks++;
    if (ohBit !== exp) begin
      failures++;
      $display("FAIL %s word=%0d bit=%0d actual=%b expected=%b", req, wordIdx, bitIdx, ohBit, exp);
    end
  endtask

  // One cycle: drive at negedge, model capture at posedge, compare at next negedge
  task automatic tick(int w, int b, int p, int c);
    wordIdx = 6'(w);
    bitIdx  = 3'(b);
    portSel = 5'(p);
    cmdSel  = 2'(c);
    @(posedge clk);
    if (!rst_n) begin
      mPort = 0; mCmd = 0;
    end else if (w == 0 && b == 0) begin
      mPort = p; mCmd = c;
    end
    @(negedge clk);
    check(reqOf(w, b), modelBit(w, b));
  endtask

  // Frame value shown only at the frame start edge; noise elsewhere (R6)
  task automatic frame(int p, int c);
    for (int w = 0; w < WORDS; w++) begin
      for (int b = 0; b < BITS; b++) begin
        if (w == 0 && b == 0) tick(w, b, p, c);
        else tick(w, b, int'($urandom_range(0, 31)), int'($urandom_range(0, 3)));
      end
    end
  endtask

  initial begin
    for (int n = 0; n < 200000; n++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R7: reset holds port 0, no action
    tick(1, 0, 31, 1);
    check("R7", 1'b1);
    tick(2, 0, 31, 1);
    check("R7", 1'b0);
    tick(24, 0, 31, 1);
    check("R7", 1'b0);
    tick(0, 0, 31, 2);  // frame start during reset is ignored
    tick(1, 0, 31, 2);
    check("R7", 1'b1);
    rst_n = 1'b1;
    // R7: after release, before any frame start
    tick(1, 0, 17, 1);
    check("R7", 1'b1);
    tick(28, 0, 17, 1);
    check("R7", 1'b0);

    frame(31, 1);  // R2, R5
    frame(0, 2);   // R3, R5
    frame(21, 0);  // R4
    frame(10, 3);  // R4 alternate code
    frame(16, 1);
    frame(1, 2);
    for (int k = 0; k < 28; k++) begin
      frame(int'($urandom_range(0, 31)), int'($urandom_range(0, 3)));  // R6 noise
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule